// File: doc/BRIEF.md
# Committed-Store Writeback Queue

This block holds the stores of one hardware thread between dispatch and the moment their data has been handed to the data cache. Dispatch appends stores at the tail in program order, each with a sequence number. The slot index returned at allocation is later used by the execute stage to deposit the store's address, byte count, split flag and up to sixteen data bytes. Retirement sends a sequence number that commits every older store. A writeback pointer walks the queue in order and offers committed stores to a cache write port. A pipeline flush sends a sequence number above which stores are discarded.

The writeback path is a two-state machine. In `WB_FIRST` it offers the store under the writeback pointer as a whole, or only its lower part if the store crosses a cache line. An accepted split store takes the transition `WB_FIRST -> WB_SECOND`, where the upper part is offered. The transition `WB_SECOND -> WB_FIRST` is taken when that second part is accepted. An accepted unsplit store stays in `WB_FIRST`. In both cases the entry is marked complete and the writeback pointer steps forward. A slot is released only when it is complete and at the head, and the head moves by at most one slot per cycle. One slot is always kept empty so that a full queue can be told apart from an empty one.

Top module: `sq_store_queue`

## Requirements
- R1: During and straight after reset the queue is empty: `sq_empty`=1, `sq_full`=0, `wr_valid`=0, `wb_pending`=0, `alloc_idx`=0.
- R2: An allocation with `alloc_valid`=1 while the queue is not full and no squash is present writes the store into slot `alloc_idx` (the tail). Its flags start cleared, and the tail advances by one.
- R3: `sq_full` is 1 exactly when DEPTH-1 slots are occupied, and an allocation in that state is ignored. `sq_empty` is 1 exactly when no slot is occupied.
- R4: An execute write to an occupied slot stores address, size, split flag and data. When `exec_size` exceeds 16, `exec_reject` is 1 in the same cycle and the slot keeps its previous contents.
- R5: A commit with sequence number S marks every occupied, not yet committed store whose sequence number is below S as committed and eligible for writeback.
- R6: `wr_valid` is 1 only when the store under the writeback pointer is committed, is not complete and `mem_blocked` is 0. In `WB_SECOND`, `wr_valid` equals `!mem_blocked`. An offer stays up with the same address until `wr_ready` takes it or `mem_blocked` rises.
- R7: An unsplit store is sent as one request carrying its own address, size and data, with `wr_second`=0.
- R8: A split store is sent as two requests with line size 16. The first (`wr_second`=0) has the store address and size L = 16 - (address mod 16), and the data is unshifted. The second (`wr_second`=1) has address + L and size - L, and the data is shifted right by 8*L bits.
- R9: Acceptance of the last request of a store marks it complete. A complete store at the head is released one cycle later. `wb_pending` counts the occupied stores that are committed but not complete.
- R10: A squash with sequence number S moves the tail back to the oldest occupied store whose sequence number exceeds S. An allocation in the same cycle is ignored.
- R11: Head, tail and writeback pointers wrap modulo DEPTH (a power of two), so `alloc_idx` runs 0..DEPTH-1 cyclically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation takes |
| sq_full | output | 1 | DEPTH-1 slots occupied |
| sq_empty | output | 1 | No slot occupied |
| exec_valid | input | 1 | Execute-stage write of a slot |
| exec_idx | input | log2(DEPTH) | Slot to write |
| exec_addr | input | ADDR_W | Store byte address |
| exec_size | input | log2(DATA_BYTES)+2 | Store byte count |
| exec_split | input | 1 | Store crosses a line boundary |
| exec_data | input | 8*DATA_BYTES | Store data, byte 0 in bits 7:0 |
| exec_reject | output | 1 | Execute write refused for size |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Stores older than this commit |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are dropped |
| mem_blocked | input | 1 | Memory system refuses stores this cycle |
| wr_valid | output | 1 | Cache write request offered |
| wr_ready | input | 1 | Cache accepts the offered request |
| wr_addr | output | ADDR_W | Request address |
| wr_size | output | log2(DATA_BYTES)+2 | Request byte count |
| wr_data | output | 8*DATA_BYTES | Request data, first byte in bits 7:0 |
| wr_second | output | 1 | Request is the upper part of a split store |
| wb_pending | output | log2(DEPTH)+1 | Committed stores not yet complete |

## Verification
The assertions take for granted that sequence numbers rise strictly along the queue and that a squash never removes a committed store. They also assume a commit only covers stores whose execute write has already arrived, and that an execute write targets a slot that has not been filled before. Under these conditions an offered store cannot change while it waits. The stimulus builds every commit number from the leading run of filled stores, and every squash number from a store at or beyond the last committed one. Valid execute writes go only to unfilled slots, and oversized writes, which are refused, go to any slot. A squash cycle carries no other request.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [0:0] {
        WB_FIRST  = 1'b0,
        WB_SECOND = 1'b1
    } wb_state_e;
endpackage

// File: rtl/sq_part_sel.sv
module sq_part_sel #(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 16,
    parameter int LINE_BYTES = 16,
    parameter int SZW        = 6
) (
    input  logic [ADDR_W-1:0]       ent_addr,
    input  logic [SZW-1:0]          ent_size,
    input  logic                    ent_split,
    input  logic [DATA_BYTES*8-1:0] ent_data,
    input  logic                    second,
    output logic [ADDR_W-1:0]       part_addr,
    output logic [SZW-1:0]          part_size,
    output logic [DATA_BYTES*8-1:0] part_data
);
    localparam int OFFW = $clog2(LINE_BYTES);

    logic [OFFW-1:0] line_off;
    logic [SZW-1:0]  low_size;

    assign line_off = ent_addr[OFFW-1:0];
    assign low_size = SZW'(LINE_BYTES) - SZW'(line_off);

    always_comb begin
        part_addr = ent_addr;
        part_size = ent_size;
        part_data = ent_data;
        if (ent_split) begin
            if (!second) begin
                part_size = low_size;
            end else begin
                part_addr = ent_addr + ADDR_W'(low_size);
                part_size = ent_size - low_size;
                part_data = ent_data >> {low_size, 3'b000};
            end
        end
    end
endmodule

// File: rtl/sq_wb_fsm.sv
module sq_wb_fsm
    import sq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ent_ready,
    input  logic ent_split,
    input  logic mem_blocked,
    input  logic wr_ready,
    output logic wr_valid,
    output logic second,
    output logic ent_done
);
    wb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WB_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_FIRST:  if (ent_ready && wr_ready && ent_split) state_d = WB_SECOND;
            WB_SECOND: if (!mem_blocked && wr_ready)            state_d = WB_FIRST;
            default:   state_d = WB_FIRST;
        endcase
    end

    always_comb begin
        wr_valid = 1'b0;
        second   = 1'b0;
        ent_done = 1'b0;
        unique case (state_q)
            WB_FIRST: begin
                wr_valid = ent_ready;
                ent_done = ent_ready && wr_ready && !ent_split;
            end
            WB_SECOND: begin
                second   = 1'b1;
                wr_valid = !mem_blocked;
                ent_done = !mem_blocked && wr_ready;
            end
            default: ;
        endcase
    end

    AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second) |-> $past(wr_valid && wr_ready && ent_split)); // R8
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue #(
    parameter int DEPTH      = 8,
    parameter int SEQ_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 16,
    parameter int LINE_BYTES = 16,
    localparam int PW  = $clog2(DEPTH),
    localparam int DW  = DATA_BYTES * 8,
    localparam int SZW = $clog2(DATA_BYTES) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic [PW-1:0]     alloc_idx,
    output logic              sq_full,
    output logic              sq_empty,
    input  logic              exec_valid,
    input  logic [PW-1:0]     exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [SZW-1:0]    exec_size,
    input  logic              exec_split,
    input  logic [DW-1:0]     exec_data,
    output logic              exec_reject,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              mem_blocked,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SZW-1:0]    wr_size,
    output logic [DW-1:0]     wr_data,
    output logic              wr_second,
    output logic [PW:0]       wb_pending
);
    logic [PW-1:0]     head_ptr, tail_ptr, wb_ptr, occ_cnt, tail_cut;
    logic [SEQ_W-1:0]  e_seq  [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [SZW-1:0]    e_size [DEPTH];
    logic [DW-1:0]     e_data [DEPTH];
    logic [DEPTH-1:0]  e_split, e_canwb, e_commit, e_done, occ;
    logic              do_alloc, exec_ok, retire, ent_ready, ent_done;

    assign occ_cnt   = tail_ptr - head_ptr;
    assign sq_full   = (occ_cnt == PW'(DEPTH - 1));
    assign sq_empty  = (occ_cnt == '0);
    assign alloc_idx = tail_ptr;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_occ
        assign occ[gi] = (PW'(gi) - head_ptr) < occ_cnt;
    end

    assign do_alloc    = alloc_valid && !sq_full && !squash_valid;
    assign exec_ok     = exec_valid && (exec_size <= SZW'(DATA_BYTES));
    assign exec_reject = exec_valid && !exec_ok;
    assign retire      = !sq_empty && e_done[head_ptr];
    assign ent_ready   = (wb_ptr != tail_ptr) && e_canwb[wb_ptr] &&
                         !e_done[wb_ptr] && !mem_blocked;

    always_comb begin : cut_scan
        logic          found;
        logic [PW-1:0] pos;
        tail_cut = tail_ptr;
        found    = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            pos = head_ptr + PW'(k);
            if (!found && occ[pos] && (e_seq[pos] > squash_seq)) begin
                tail_cut = pos;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        wb_pending = '0;
        for (int i = 0; i < DEPTH; i++)
            if (occ[i] && e_commit[i] && !e_done[i]) wb_pending = wb_pending + 1'b1;
    end

    sq_wb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_ready  (ent_ready),
        .ent_split  (e_split[wb_ptr]),
        .mem_blocked(mem_blocked),
        .wr_ready   (wr_ready),
        .wr_valid   (wr_valid),
        .second     (wr_second),
        .ent_done   (ent_done)
    );

    sq_part_sel #(
        .ADDR_W    (ADDR_W),
        .DATA_BYTES(DATA_BYTES),
        .LINE_BYTES(LINE_BYTES),
        .SZW       (SZW)
    ) u_part (
        .ent_addr (e_addr[wb_ptr]),
        .ent_size (e_size[wb_ptr]),
        .ent_split(e_split[wb_ptr]),
        .ent_data (e_data[wb_ptr]),
        .second   (wr_second),
        .part_addr(wr_addr),
        .part_size(wr_size),
        .part_data(wr_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            wb_ptr   <= '0;
            e_split  <= '0;
            e_canwb  <= '0;
            e_commit <= '0;
            e_done   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                e_seq[i]  <= '0;
                e_addr[i] <= '0;
                e_size[i] <= '0;
                e_data[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (commit_valid && occ[i] && !e_commit[i] && (e_seq[i] < commit_seq)) begin
                    e_commit[i] <= 1'b1;
                    e_canwb[i]  <= 1'b1;
                end
                if (ent_done && (wb_ptr == PW'(i)))
                    e_done[i] <= 1'b1;
                if (exec_ok && occ[i] && (exec_idx == PW'(i))) begin
                    e_addr[i]  <= exec_addr;
                    e_size[i]  <= exec_size;
                    e_split[i] <= exec_split;
                    e_data[i]  <= exec_data;
                end
                if (do_alloc && (tail_ptr == PW'(i))) begin
                    e_seq[i]    <= alloc_seq;
                    e_addr[i]   <= '0;
                    e_size[i]   <= '0;
                    e_data[i]   <= '0;
                    e_split[i]  <= 1'b0;
                    e_canwb[i]  <= 1'b0;
                    e_commit[i] <= 1'b0;
                    e_done[i]   <= 1'b0;
                end
            end
            if (retire)   head_ptr <= head_ptr + 1'b1;
            if (ent_done) wb_ptr   <= wb_ptr + 1'b1;
            if (squash_valid)  tail_ptr <= tail_cut;
            else if (do_alloc) tail_ptr <= tail_ptr + 1'b1;
        end
    end

    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_full && alloc_valid && !squash_valid) |=> (tail_ptr == $past(tail_ptr))); // R3
    AST_OFFER_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !mem_blocked); // R6
    AST_OFFER_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_second) |-> (e_commit[wb_ptr] && !e_done[wb_ptr])); // R6
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (mem_blocked || (wr_valid && $stable(wr_addr)))); // R6
    AST_SECOND_IS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_second |-> e_split[wb_ptr]); // R8
    AST_HEAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_empty && e_done[head_ptr]) |=> (head_ptr == PW'($past(head_ptr) + 1'b1))); // R9
endmodule

// File: tb/sq_store_queue_tb.sv
module sq_store_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int SEQ_W = 16;
    localparam int ADDR_W = 32;
    localparam int DB = 16;
    localparam int DW = 128;
    localparam int PW = 3;
    localparam int SZW = 6;

    logic              clk, rst_n;
    logic              alloc_valid;
    logic [SEQ_W-1:0]  alloc_seq;
    logic [PW-1:0]     alloc_idx;
    logic              sq_full, sq_empty;
    logic              exec_valid;
    logic [PW-1:0]     exec_idx;
    logic [ADDR_W-1:0] exec_addr;
    logic [SZW-1:0]    exec_size;
    logic              exec_split;
    logic [DW-1:0]     exec_data;
    logic              exec_reject;
    logic              commit_valid;
    logic [SEQ_W-1:0]  commit_seq;
    logic              squash_valid;
    logic [SEQ_W-1:0]  squash_seq;
    logic              mem_blocked;
    logic              wr_valid, wr_ready;
    logic [ADDR_W-1:0] wr_addr;
    logic [SZW-1:0]    wr_size;
    logic [DW-1:0]     wr_data;
    logic              wr_second;
    logic [PW:0]       wb_pending;

    sq_store_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_BYTES(DB), .LINE_BYTES(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .alloc_idx(alloc_idx), .sq_full(sq_full), .sq_empty(sq_empty),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
        .exec_size(exec_size), .exec_split(exec_split), .exec_data(exec_data),
        .exec_reject(exec_reject), .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .mem_blocked(mem_blocked),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_second(wr_second), .wb_pending(wb_pending)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int          mq_seq[$];
    bit [31:0]   mq_addr[$];
    int          mq_size[$];
    bit          mq_split[$];
    bit [127:0]  mq_data[$];
    bit          mq_com[$];
    bit          mq_done[$];
    bit          mq_fill[$];
    int m_head = 0;
    int m_wb = 0;
    int m_phase = 0;
    int next_seq = 1;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check_cycle();
        int n = mq_seq.size();
        bit ev = 0;
        int pend = 0;
        int low;
        bit [31:0] ea;
        int es;
        bit [127:0] ed;
        chk("R3 sq_full", sq_full, n == DEPTH - 1);
        chk("R3 sq_empty", sq_empty, n == 0);
        chk("R2 R10 R11 alloc_idx", alloc_idx, (m_head + n) % DEPTH);
        if (m_phase == 0) begin
            if (m_wb < n) ev = mq_com[m_wb] && !mq_done[m_wb] && !mem_blocked;
        end else ev = !mem_blocked;
        chk("R5 R6 wr_valid", wr_valid, ev);
        if (ev) begin
            ea = mq_addr[m_wb]; es = mq_size[m_wb]; ed = mq_data[m_wb];
            if (!mq_split[m_wb]) begin
                chk("R7 wr_addr", wr_addr, ea);
                chk("R7 wr_size", wr_size, es);
                chk("R7 wr_data", wr_data, ed);
                chk("R7 wr_second", wr_second, 0);
            end else begin
                low = 16 - (ea % 16);
                if (m_phase == 0) begin
                    chk("R8 wr_addr", wr_addr, ea);
                    chk("R8 wr_size", wr_size, low);
                    chk("R8 wr_data", wr_data, ed);
                end else begin
                    chk("R8 wr_addr", wr_addr, ea + low);
                    chk("R8 wr_size", wr_size, es - low);
                    chk("R8 wr_data", wr_data, ed >> (8 * low));
                end
                chk("R8 wr_second", wr_second, m_phase);
            end
        end
        for (int j = 0; j < n; j++) if (mq_com[j] && !mq_done[j]) pend++;
        chk("R9 wb_pending", wb_pending, pend);
        chk("R4 exec_reject", exec_reject, exec_valid && (exec_size > DB));
    endtask

    task automatic model_step();
        int n = mq_seq.size();
        bit pop = (n > 0) && mq_done[0];
        bit ev = 0;
        int pos;
        if (m_phase == 0) begin
            if (m_wb < n) ev = mq_com[m_wb] && !mq_done[m_wb] && !mem_blocked;
        end else ev = !mem_blocked;
        if (ev && wr_ready) begin
            if (m_phase == 0 && mq_split[m_wb]) m_phase = 1;
            else begin
                mq_done[m_wb] = 1;
                m_wb++;
                m_phase = 0;
            end
        end
        if (commit_valid)
            for (int j = 0; j < n; j++)
                if (!mq_com[j] && mq_seq[j] < int'(commit_seq)) mq_com[j] = 1;
        if (exec_valid && exec_size <= DB) begin
            pos = (int'(exec_idx) - m_head + DEPTH) % DEPTH;
            if (pos < n) begin
                mq_addr[pos] = exec_addr; mq_size[pos] = exec_size;
                mq_split[pos] = exec_split; mq_data[pos] = exec_data; mq_fill[pos] = 1;
            end
        end
        if (squash_valid) begin
            while (mq_seq.size() > 0 && mq_seq[mq_seq.size() - 1] > int'(squash_seq)) begin
                void'(mq_seq.pop_back()); void'(mq_addr.pop_back()); void'(mq_size.pop_back());
                void'(mq_split.pop_back()); void'(mq_data.pop_back()); void'(mq_com.pop_back());
                void'(mq_done.pop_back()); void'(mq_fill.pop_back());
            end
        end else if (alloc_valid && n != DEPTH - 1) begin
            mq_seq.push_back(int'(alloc_seq)); mq_addr.push_back(0); mq_size.push_back(0);
            mq_split.push_back(0); mq_data.push_back(0); mq_com.push_back(0);
            mq_done.push_back(0); mq_fill.push_back(0);
            next_seq++;
        end
        if (pop) begin
            void'(mq_seq.pop_front()); void'(mq_addr.pop_front()); void'(mq_size.pop_front());
            void'(mq_split.pop_front()); void'(mq_data.pop_front()); void'(mq_com.pop_front());
            void'(mq_done.pop_front()); void'(mq_fill.pop_front());
            m_head = (m_head + 1) % DEPTH;
            m_wb--;
        end
    endtask

    task automatic drive(input int mode);
        int n = mq_seq.size();
        int f = -1;
        int lead = 0;
        int c = 0;
        int k;
        alloc_valid = 0; exec_valid = 0; commit_valid = 0; squash_valid = 0;
        alloc_seq = SEQ_W'(next_seq);
        for (int j = 0; j < n; j++) if (f < 0 && !mq_fill[j]) f = j;
        for (int j = 0; j < n; j++) if (mq_fill[j] && lead == j) lead++;
        for (int j = 0; j < n; j++) if (mq_com[j]) c = j + 1;
        if (mode == 1) begin
            alloc_valid = 1; mem_blocked = 0; wr_ready = 0;
            return;
        end
        mem_blocked = (mode == 2) ? 1'b0 : ($urandom % 7 == 0);
        wr_ready    = (mode == 2) ? 1'b1 : ($urandom % 5 < 3);
        if (mode == 0 && n > c && $urandom % 20 == 0) begin
            squash_valid = 1;
            k = c + int'($urandom % (n - c));
            squash_seq = (k == 0) ? SEQ_W'(mq_seq[0] - 1) : SEQ_W'(mq_seq[k - 1]);
            return;
        end
        alloc_valid = (mode == 0) && ($urandom % 10 < 6);
        if (f >= 0 && (mode == 2 || $urandom % 2 == 0)) begin
            exec_valid = 1;
            exec_idx   = PW'((m_head + f) % DEPTH);
            exec_addr  = $urandom;
            exec_size  = SZW'(1 + $urandom % 16);
            exec_split = (exec_addr % 16) + exec_size > 16;
            exec_data  = rnd128();
        end else if (mode == 0 && n > 0 && $urandom % 4 == 0) begin
            exec_valid = 1;
            exec_idx   = PW'((m_head + int'($urandom % n)) % DEPTH);
            exec_addr  = $urandom;
            exec_size  = SZW'(17 + $urandom % 40);
            exec_split = $urandom % 2;
            exec_data  = rnd128();
        end
        if (lead > 0 && (mode == 2 || $urandom % 3 == 0)) begin
            commit_valid = 1;
            k = (mode == 2) ? lead : 1 + int'($urandom % lead);
            commit_seq = SEQ_W'(mq_seq[k - 1] + 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; alloc_valid = 0; alloc_seq = 0; exec_valid = 0; exec_idx = 0;
        exec_addr = 0; exec_size = 0; exec_split = 0; exec_data = 0;
        commit_valid = 0; commit_seq = 0; squash_valid = 0; squash_seq = 0;
        mem_blocked = 0; wr_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 sq_empty", sq_empty, 1);
        chk("R1 sq_full", sq_full, 0);
        chk("R1 wr_valid", wr_valid, 0);
        chk("R1 wb_pending", wb_pending, 0);
        chk("R1 alloc_idx", alloc_idx, 0);
        @(posedge clk); #1;
        rst_n = 1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            drive(cyc < 12 ? 1 : (cyc >= 3700 ? 2 : 0));
            @(negedge clk);
            check_cycle();
            model_step();
            @(posedge clk); #1;
        end
        @(negedge clk);
        chk("R9 drained sq_empty", sq_empty, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule